// File: doc/BRIEF.md
# Transmit Disable and Laser Fault Controller

This block decides when the laser of an optical transmitter module may emit light. Two disable sources, an external disable pin and a software disable bit, are combined so that either one switches the laser off. A laser fault reported by the analog front end is latched. The latch keeps the laser dark until the host holds disable asserted without a break for a minimum number of clock cycles and then releases it.

Each time the laser restarts, whether after reset, after disable is released or after a fault is cleared, the block runs an initialization window. During this window the laser is driven and fault reports are ignored, so a transient failure can settle. At the end of the window, a fault that is still present latches again. The host reads back the synchronized pin state, the latched fault, the software disable bit and a not-ready bit that falls once the first initialization has completed.

Both the disable pin and the fault input are asynchronous and pass through a synchronizer chain before use. All durations are parameters counted in clock cycles.

Top module: `txdis_fault_ctrl`

## Requirements
- R1: The laser is disabled whenever the synchronized disable pin is 1 or the software disable bit is 1. The two conditions are ORed, and clearing one while the other is still 1 keeps `laser_en` at 0.
- R2: `laser_en` falls to 0 no more than 4 clock cycles after `tx_dis_pin` rises. It falls no more than 2 cycles after `soft_dis` rises.
- R3: A synchronized fault seen while the laser is active sets `flt_out` to 1 and `laser_en` to 0 within 4 cycles. Both stay that way after the fault input returns to 0.
- R4: A latched fault clears only when disable (pin OR soft bit) is held continuously for at least RESET_CYCLES+1 synchronized cycles and then released. A shorter pulse leaves the fault latched. Each new rising edge of disable restarts the hold count, so several short pulses never add up to a clear.
- R5: After reset, after disable is released, or after a fault is cleared, the block spends INIT_CYCLES cycles initializing with `laser_en` at 1 and fault input ignored (`flt_out` at 0). `laser_en` returns to 1 within 4 cycles of disable release.
- R6: If the fault input is still 1 when initialization ends, the fault latches again (`flt_out` 1, `laser_en` 0). If the fault went away during the window, the laser stays on with `flt_out` at 0.
- R7: `stat_dis_pin` shows the synchronized disable pin, `stat_flt` shows `flt_out`, and `stat_soft_dis` shows the software disable bit.
- R8: `stat_not_ready` is 1 from reset until the first initialization window completes. It then reads 0 and never returns to 1 without a reset.
- R9: During reset, `flt_out` is 0, `stat_not_ready` is 1 and the block is in its initialization state with `laser_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_dis_pin | input | 1 | External disable pin, asynchronous, 1 = disable |
| soft_dis | input | 1 | Software disable bit, synchronous, 1 = disable |
| laser_flt | input | 1 | Laser fault report from the front end, asynchronous |
| laser_en | output | 1 | Laser enable, 1 = emit |
| flt_out | output | 1 | Latched fault indication |
| stat_dis_pin | output | 1 | Readback of the synchronized disable pin |
| stat_flt | output | 1 | Readback of the fault indication |
| stat_soft_dis | output | 1 | Readback of the software disable bit |
| stat_not_ready | output | 1 | 1 until the first initialization completes |

## Verification
The disable function is exercised in several ways: the pin alone, the software bit alone, both together, and one released while the other is held. This separates a correct OR from a design that follows only one source.

Fault clearing is driven with three kinds of disable pulse:
- a single long pulse, which must clear the fault;
- a single short pulse, which must leave it latched;
- a train of short pulses whose total length exceeds the reset time, which must also leave it latched, exposing a hold count that fails to restart.

The initialization window is driven with two kinds of fault:
- a fault that vanishes before the window ends, which must not latch;
- a fault that persists, which must latch again at the end of the window.

// File: rtl/txdis_pkg.sv
package txdis_pkg;
   typedef enum logic [2:0] {
      ST_RESET_INIT   = 3'd0,
      ST_ACTIVE       = 3'd1,
      ST_DISABLED     = 3'd2,
      ST_FAULT        = 3'd3,
      ST_FAULT_RST_WT = 3'd4
   } txdis_state_e;
endpackage

// File: rtl/txdis_sync.sv
module txdis_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   initial begin
      if (STAGES < 2) $error("txdis_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("txdis_sync: WIDTH must be at least 1");
   end

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_async[b]};
         end
         assign q_sync[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/txdis_timer.sv
module txdis_timer #(
   parameter int CW        = 8,
   parameter int RST_VALUE = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= CW'(RST_VALUE);
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/txdis_fsm.sv
module txdis_fsm
   import txdis_pkg::*;
#(
   parameter int CW           = 8,
   parameter int INIT_CYCLES  = 100,
   parameter int RESET_CYCLES = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dis_any,
   input  logic         flt_sync,
   input  logic         tmr_expired,
   output logic         tmr_load,
   output logic [CW-1:0] tmr_val,
   output txdis_state_e state,
   output logic         init_done
);
   txdis_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RESET_INIT: begin
            if (dis_any)          nxt = ST_DISABLED;
            else if (tmr_expired) nxt = flt_sync ? ST_FAULT : ST_ACTIVE;
         end
         ST_ACTIVE: begin
            if (flt_sync)     nxt = ST_FAULT;
            else if (dis_any) nxt = ST_DISABLED;
         end
         ST_DISABLED: begin
            if (!dis_any) nxt = ST_RESET_INIT;
         end
         ST_FAULT: begin
            if (dis_any) nxt = ST_FAULT_RST_WT;
         end
         ST_FAULT_RST_WT: begin
            if (!dis_any) nxt = tmr_expired ? ST_RESET_INIT : ST_FAULT;
         end
         default: nxt = ST_FAULT;
      endcase
   end

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = CW'(INIT_CYCLES);
      if (nxt == ST_RESET_INIT && state != ST_RESET_INIT) begin
         tmr_load = 1'b1;
         tmr_val  = CW'(INIT_CYCLES);
      end else if (nxt == ST_FAULT_RST_WT && state != ST_FAULT_RST_WT) begin
         tmr_load = 1'b1;
         tmr_val  = CW'(RESET_CYCLES);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RESET_INIT;
         init_done <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_RESET_INIT && !dis_any && tmr_expired)
            init_done <= 1'b1;
      end
   end
endmodule

// File: rtl/txdis_fault_ctrl.sv
module txdis_fault_ctrl
   import txdis_pkg::*;
#(
   parameter int INIT_CYCLES  = 1000,
   parameter int RESET_CYCLES = 100,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_dis_pin,
   input  logic soft_dis,
   input  logic laser_flt,
   output logic laser_en,
   output logic flt_out,
   output logic stat_dis_pin,
   output logic stat_flt,
   output logic stat_soft_dis,
   output logic stat_not_ready
);
   localparam int MAXC = (INIT_CYCLES > RESET_CYCLES) ? INIT_CYCLES : RESET_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);

   initial begin
      if (INIT_CYCLES < 1)  $error("txdis_fault_ctrl: INIT_CYCLES must be >= 1");
      if (RESET_CYCLES < 1) $error("txdis_fault_ctrl: RESET_CYCLES must be >= 1");
   end

   logic [1:0]   sync_q;
   logic         dis_sync, flt_sync, dis_any;
   logic         tmr_load, tmr_expired, init_done;
   logic [CW-1:0] tmr_val;
   txdis_state_e state;

   txdis_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({laser_flt, tx_dis_pin}),
      .q_sync  (sync_q)
   );
   assign dis_sync = sync_q[0];
   assign flt_sync = sync_q[1];
   assign dis_any  = dis_sync | soft_dis;

   txdis_timer #(.CW(CW), .RST_VALUE(INIT_CYCLES)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   txdis_fsm #(.CW(CW), .INIT_CYCLES(INIT_CYCLES), .RESET_CYCLES(RESET_CYCLES)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .dis_any     (dis_any),
      .flt_sync    (flt_sync),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .state       (state),
      .init_done   (init_done)
   );

   assign laser_en       = (state == ST_RESET_INIT) || (state == ST_ACTIVE);
   assign flt_out        = (state == ST_FAULT) || (state == ST_FAULT_RST_WT);
   assign stat_dis_pin   = dis_sync;
   assign stat_flt       = flt_out;
   assign stat_soft_dis  = soft_dis;
   assign stat_not_ready = !init_done;
endmodule

// File: rtl/txdis_fault_ctrl_chk.sv
module txdis_fault_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic soft_dis,
   input logic laser_en,
   input logic flt_out,
   input logic stat_not_ready,
   input logic tmr_expired,
   input logic dis_any
);
   // R1 / R2: software disable switches the laser off on the next cycle
   a_r2_soft_off: assert property (@(posedge clk) disable iff (!rst_n)
      soft_dis |=> !laser_en);

   // R3: a latched fault always keeps the laser dark
   a_r3_fault_dark: assert property (@(posedge clk) disable iff (!rst_n)
      flt_out |-> !laser_en);

   // R4: the fault clears only after the hold timer has run out
   a_r4_clear_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_out) |-> $past(tmr_expired) && !$past(dis_any));

   // R5: the laser restarts only with no fault shown
   a_r5_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(laser_en) |-> !flt_out);

   // R8: once ready, never not-ready again
   a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_not_ready |=> !stat_not_ready);
endmodule

bind txdis_fault_ctrl txdis_fault_ctrl_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .soft_dis       (soft_dis),
   .laser_en       (laser_en),
   .flt_out        (flt_out),
   .stat_not_ready (stat_not_ready),
   .tmr_expired    (tmr_expired),
   .dis_any        (dis_any)
);

// File: tb/sim_txdis_fault_ctrl.sv
module sim_txdis_fault_ctrl;
   localparam int INIT_C = 40;
   localparam int RST_C  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_dis_pin = 1'b0, soft_dis = 1'b0, laser_flt = 1'b0;
   logic laser_en, flt_out, stat_dis_pin, stat_flt, stat_soft_dis, stat_not_ready;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   txdis_fault_ctrl #(.INIT_CYCLES(INIT_C), .RESET_CYCLES(RST_C)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_dis_pin(tx_dis_pin), .soft_dis(soft_dis),
      .laser_flt(laser_flt), .laser_en(laser_en), .flt_out(flt_out),
      .stat_dis_pin(stat_dis_pin), .stat_flt(stat_flt),
      .stat_soft_dis(stat_soft_dis), .stat_not_ready(stat_not_ready)
   );

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic t_reset;
      chk("R9 flt_out in reset", flt_out, 1'b0);
      chk("R9 not_ready in reset", stat_not_ready, 1'b1);
      chk("R9 laser_en in reset", laser_en, 1'b1);
      rst_n = 1'b1;
      cyc(INIT_C / 2);
      chk("R8 not_ready mid init", stat_not_ready, 1'b1);
      cyc(INIT_C);
      chk("R8 not_ready after init", stat_not_ready, 1'b0);
      chk("R5 laser on after init", laser_en, 1'b1);
   endtask

   task automatic t_pin_soft;
      tx_dis_pin = 1'b1;
      cyc(4);
      chk("R2 pin off latency", laser_en, 1'b0);
      chk("R7 stat_dis_pin", stat_dis_pin, 1'b1);
      soft_dis = 1'b1;
      tx_dis_pin = 1'b0;
      cyc(6);
      chk("R1 soft holds off after pin release", laser_en, 1'b0);
      chk("R7 stat_soft_dis", stat_soft_dis, 1'b1);
      chk("R7 stat_dis_pin cleared", stat_dis_pin, 1'b0);
      soft_dis = 1'b0;
      cyc(4);
      chk("R5 turn-on after release", laser_en, 1'b1);
      chk("R8 not_ready stays 0", stat_not_ready, 1'b0);
      cyc(INIT_C + 5);
      soft_dis = 1'b1;
      cyc(2);
      chk("R2 soft off latency", laser_en, 1'b0);
      soft_dis = 1'b0;
      cyc(INIT_C + 5);
      chk("R1 on with both clear", laser_en, 1'b1);
   endtask

   task automatic t_fault_latch;
      laser_flt = 1'b1;
      cyc(4);
      chk("R3 fault asserted", flt_out, 1'b1);
      chk("R3 laser off on fault", laser_en, 1'b0);
      chk("R7 stat_flt", stat_flt, 1'b1);
      laser_flt = 1'b0;
      cyc(10);
      chk("R3 fault stays latched", flt_out, 1'b1);
   endtask

   task automatic t_short_pulse;
      tx_dis_pin = 1'b1;
      cyc(RST_C / 2);
      tx_dis_pin = 1'b0;
      cyc(8);
      chk("R4 short pulse keeps fault", flt_out, 1'b1);
      chk("R4 short pulse keeps laser off", laser_en, 1'b0);
   endtask

   task automatic t_pulse_train;
      for (int i = 0; i < 4; i++) begin
         tx_dis_pin = 1'b1;
         cyc(RST_C - 6);
         tx_dis_pin = 1'b0;
         cyc(3);
      end
      cyc(4);
      chk("R4 pulse train keeps fault", flt_out, 1'b1);
   endtask

   task automatic t_long_pulse;
      soft_dis = 1'b1;
      cyc(RST_C + 10);
      chk("R4 fault shown during hold", flt_out, 1'b1);
      soft_dis = 1'b0;
      cyc(3);
      chk("R4 long pulse clears fault", flt_out, 1'b0);
      chk("R5 laser on in init", laser_en, 1'b1);
   endtask

   task automatic t_transient_in_init;
      laser_flt = 1'b1;
      cyc(5);
      chk("R5 fault ignored in init", flt_out, 1'b0);
      laser_flt = 1'b0;
      cyc(INIT_C + 5);
      chk("R6 transient does not latch", flt_out, 1'b0);
      chk("R6 laser on after transient", laser_en, 1'b1);
   endtask

   task automatic t_persistent;
      laser_flt = 1'b1;
      cyc(4);
      chk("R3 second fault latched", flt_out, 1'b1);
      tx_dis_pin = 1'b1;
      cyc(RST_C + 10);
      tx_dis_pin = 1'b0;
      cyc(5);
      chk("R5 fault hidden in re-init", flt_out, 1'b0);
      cyc(INIT_C + 5);
      chk("R6 persistent fault relatches", flt_out, 1'b1);
      chk("R6 laser off after relatch", laser_en, 1'b0);
      laser_flt = 1'b0;
   endtask

   initial begin
      #1;
      cyc(3);
      t_reset();
      t_pin_soft();
      t_fault_latch();
      t_short_pulse();
      t_pulse_train();
      t_long_pulse();
      t_transient_in_init();
      t_persistent();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule